// File: doc/BRIEF.md
# I2C Register-Pointer Slave Interface

This block is the serial front end of a small configuration slave. An oversampling system clock watches the SCL and SDA lines through two-flop synchronizers and detects START, STOP and repeated START conditions. When an address byte matches the fixed five-bit device prefix plus a two-bit select code, the slave acknowledges. It then treats the first written byte as a register pointer. Each later byte goes into the register the pointer selects, and the pointer steps up by one. Reads return data from the stored pointer onward, with the same step after every byte. The pointer survives from one transaction to the next.

The register file holds four port registers at 0x01 to 0x04 and two device configuration registers at 0x26 and 0x27. Two mechanisms return the interface to idle and release SDA. The first is a stuck-bus watchdog, which one configuration bit arms. The second is an active-low external reset. A configuration bit can make that reset also restore the register file.

Top module: `i2c_regptr_slave`

## Requirements
- R1: After the power-up reset (rst_ni low), the port registers at 0x01..0x04 read 0x80, register 0x26 reads 0xEC, register 0x27 reads 0x8F, and sda_oe_o is 0. Whenever the interface is idle, sda_oe_o is 0.
- R2: The slave acknowledges an address byte only if bits 7..3 are 10011 and bits 2..1 equal the select code. Bit 0 is the read (1) or write (0) flag. Acknowledging means driving sda_oe_o high for the ninth clock. A mismatched address gets no ACK, and the bytes that follow are ignored until the next START. SDA output changes only while SCL is low.
- R3: The first byte written after the address loads the pointer. A STOP that follows it changes no register.
- R4: Each further written byte is stored in the register the pointer selects and acknowledged, and the pointer then advances by one.
- R5: A read sends the register at the stored pointer, MSB first. The pointer advances after each byte sent, and the pointer kept from an earlier transaction is used.
- R6: Addresses other than 0x01..0x04, 0x26 and 0x27 read as 0x00 and ignore writes, but the pointer still steps through them (0x04 to 0x05, 0x27 to 0x28).
- R7: When the master answers a read byte with NACK, the slave releases SDA and drives nothing more until a new START.
- R8: A repeated START ends the current transfer and begins a new address phase. This allows a pointer write followed by a read in one transaction.
- R9: When bit 7 of 0x27 is 0 and SCL or SDA stays low for TMO_CYC system clocks during a transfer, the interface goes idle and releases SDA. When that bit is 1, no timeout occurs.
- R10: While bus_rst_ni is low, the interface is held idle with SDA released. If bit 0 of 0x26 is 1, all registers also return to their power-up values. If that bit is 0, the registers are kept.
- R11: The two-bit address select input is captured at each START and holds for the rest of that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low power-up reset |
| bus_rst_ni | input | 1 | Active-low external interface reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the wire |
| addr_sel_i | input | 2 | Address select code (address bits 2..1) |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| port_cfg_o | output | NPORT*8 (32) | Port registers, 0x01 in bits 7..0 upward |
| devcfg0_o | output | 8 | Configuration register 0x26 |
| devcfg1_o | output | 8 | Configuration register 0x27 |

## Verification
The hardest situations to reach are a bus that stalls in the middle of an acknowledge and an external reset that arrives while the slave is pulling SDA low. The bench shifts in a matching address and then stops toggling SCL, so the slave is left holding the ACK. It first does this with the watchdog armed and then with it disarmed. In the disarmed case the hold is broken only by bus_rst_ni, and at that moment the register-restore bit is set, so the restore is observed through the register outputs. Pointer persistence is reached by splitting a pointer write and the read that uses it across separate transactions and repeated STARTs.

// File: rtl/i2c_rp_pkg.sv
package i2c_rp_pkg;
  localparam logic [4:0] DEV_ID    = 5'b10011;
  localparam logic [7:0] PORT_BASE = 8'h01;
  localparam logic [7:0] PORT_RST  = 8'h80;
  localparam logic [7:0] CFG0_ADDR = 8'h26;
  localparam logic [7:0] CFG1_ADDR = 8'h27;
  localparam logic [7:0] CFG0_RST  = 8'hEC;
  localparam logic [7:0] CFG1_RST  = 8'h8F;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_DACK, ST_TX, ST_MACK
  } bus_st_e;
endpackage

// File: rtl/i2c_rp_sync.sv
module i2c_rp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  input  logic brst_ni,
  output logic scl_o,
  output logic sda_o,
  output logic brst_no,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic edge_o
);
  logic [STAGES-1:0] scl_sh, sda_sh, brst_sh;
  logic scl_p, sda_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sh  <= '1;
      sda_sh  <= '1;
      brst_sh <= '0;
      scl_p   <= 1'b1;
      sda_p   <= 1'b1;
    end else begin
      scl_sh  <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh  <= {sda_sh[STAGES-2:0], sda_i};
      brst_sh <= {brst_sh[STAGES-2:0], brst_ni};
      scl_p   <= scl_sh[STAGES-1];
      sda_p   <= sda_sh[STAGES-1];
    end
  end

  assign scl_o      = scl_sh[STAGES-1];
  assign sda_o      = sda_sh[STAGES-1];
  assign brst_no    = brst_sh[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_p;
  assign scl_fall_o = ~scl_o & scl_p;
  // SDA moves while SCL stays high
  assign start_o    = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_o     = scl_o & scl_p & ~sda_p & sda_o;
  assign edge_o     = (scl_o ^ scl_p) | (sda_o ^ sda_p);
endmodule

// File: rtl/i2c_rp_tmo.sv
module i2c_rp_tmo #(
  parameter int LIMIT = 4000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic active_i,
  input  logic line_low_i,
  input  logic edge_i,
  output logic fire_o
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                       cnt <= '0;
    else if (!en_i || !active_i || !line_low_i || edge_i) cnt <= '0;
    else if (cnt != CW'(LIMIT))                        cnt <= cnt + CW'(1);
  end

  assign fire_o = en_i && active_i && (cnt == CW'(LIMIT));
endmodule

// File: rtl/i2c_rp_regs.sv
module i2c_rp_regs
  import i2c_rp_pkg::*;
#(
  parameter int NPORT = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restore_i,
  input  logic               we_i,
  input  logic [7:0]         waddr_i,
  input  logic [7:0]         wdata_i,
  input  logic [7:0]         raddr_i,
  output logic [7:0]         rdata_o,
  output logic [NPORT*8-1:0] ports_o,
  output logic [7:0]         cfg0_o,
  output logic [7:0]         cfg1_o
);
  logic [NPORT-1:0][7:0] port_rd;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    localparam logic [7:0] ADR = PORT_BASE + 8'(g);
    logic [7:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                      q <= PORT_RST;
      else if (restore_i)               q <= PORT_RST;
      else if (we_i && waddr_i == ADR)  q <= wdata_i;
    end
    assign ports_o[g*8 +: 8] = q;
    assign port_rd[g]        = (raddr_i == ADR) ? q : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni || restore_i) begin
      cfg0_o <= CFG0_RST;
      cfg1_o <= CFG1_RST;
    end else if (we_i) begin
      if (waddr_i == CFG0_ADDR) cfg0_o <= wdata_i;
      if (waddr_i == CFG1_ADDR) cfg1_o <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    for (int i = 0; i < NPORT; i++) rdata_o = rdata_o | port_rd[i];
    if (raddr_i == CFG0_ADDR) rdata_o = cfg0_o;
    if (raddr_i == CFG1_ADDR) rdata_o = cfg1_o;
  end
endmodule

// File: rtl/i2c_rp_fsm.sv
module i2c_rp_fsm
  import i2c_rp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brst_ni,
  input  logic       tmo_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       sda_i,
  input  logic [1:0] sel_i,
  input  logic [7:0] rdata_i,
  output logic       oe_o,
  output logic       we_o,
  output logic [7:0] wdata_o,
  output logic [7:0] ptr_o,
  output logic       idle_o
);
  bus_st_e    st;
  logic [3:0] cnt;
  logic [7:0] shreg, tx;
  logic [1:0] sel_q;
  logic       rw, cmd_pend, nack;
  logic       go;

  assign go      = brst_ni && !tmo_i && !start_i && !stop_i;
  assign we_o    = go && st == ST_RX && scl_fall_i && cnt == 4'd8 && !cmd_pend;
  assign wdata_o = shreg;
  assign idle_o  = (st == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; cnt <= '0; shreg <= '0; tx <= '0; sel_q <= '0;
      rw <= 1'b0; cmd_pend <= 1'b0; nack <= 1'b0; oe_o <= 1'b0; ptr_o <= '0;
    end else if (!brst_ni || tmo_i) begin
      st <= ST_IDLE; oe_o <= 1'b0;
    end else if (start_i) begin
      st <= ST_ADDR; cnt <= '0; oe_o <= 1'b0; sel_q <= sel_i;
    end else if (stop_i) begin
      st <= ST_IDLE; oe_o <= 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_RX: begin
          if (scl_rise_i) begin
            shreg <= {shreg[6:0], sda_i};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall_i && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == {DEV_ID, sel_q}) begin
                st <= ST_AACK; oe_o <= 1'b1; rw <= shreg[0];
              end else begin
                st <= ST_IDLE;
              end
            end else begin
              st <= ST_DACK; oe_o <= 1'b1;
              if (cmd_pend) begin
                ptr_o <= shreg; cmd_pend <= 1'b0;
              end else begin
                ptr_o <= ptr_o + 8'd1;
              end
            end
          end
        end
        ST_AACK: if (scl_fall_i) begin
          cnt <= '0;
          if (rw) begin
            tx <= rdata_i; oe_o <= ~rdata_i[7]; st <= ST_TX;
          end else begin
            oe_o <= 1'b0; st <= ST_RX; cmd_pend <= 1'b1;
          end
        end
        ST_DACK: if (scl_fall_i) begin
          oe_o <= 1'b0; st <= ST_RX;
        end
        ST_TX: if (scl_fall_i) begin
          if (cnt == 4'd7) begin
            oe_o <= 1'b0; ptr_o <= ptr_o + 8'd1; st <= ST_MACK;
          end else begin
            cnt <= cnt + 4'd1; tx <= {tx[6:0], 1'b0}; oe_o <= ~tx[6];
          end
        end
        ST_MACK: begin
          if (scl_rise_i) nack <= sda_i;
          else if (scl_fall_i) begin
            if (nack) st <= ST_IDLE;
            else begin
              tx <= rdata_i; oe_o <= ~rdata_i[7]; cnt <= '0; st <= ST_TX;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_regptr_slave.sv
module i2c_regptr_slave
  import i2c_rp_pkg::*;
#(
  parameter int NPORT       = 4,
  parameter int TMO_CYC     = 4000,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               bus_rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [1:0]         addr_sel_i,
  output logic               sda_oe_o,
  output logic [NPORT*8-1:0] port_cfg_o,
  output logic [7:0]         devcfg0_o,
  output logic [7:0]         devcfg1_o
);
  logic scl_s, sda_s, brst_s, scl_rise, scl_fall, start, stop, bus_edge;
  logic tmo_fire, reg_we, fsm_idle;
  logic [7:0] ptr, wdata, rdata;

  i2c_rp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i, .brst_ni(bus_rst_ni),
    .scl_o(scl_s), .sda_o(sda_s), .brst_no(brst_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .edge_o(bus_edge)
  );

  i2c_rp_tmo #(.LIMIT(TMO_CYC)) u_tmo (
    .clk_i, .rst_ni,
    .en_i(~devcfg1_o[7]), .active_i(~fsm_idle),
    .line_low_i(~scl_s | ~sda_s), .edge_i(bus_edge),
    .fire_o(tmo_fire)
  );

  i2c_rp_fsm u_fsm (
    .clk_i, .rst_ni, .brst_ni(brst_s), .tmo_i(tmo_fire),
    .start_i(start), .stop_i(stop), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_i(sda_s), .sel_i(addr_sel_i), .rdata_i(rdata),
    .oe_o(sda_oe_o), .we_o(reg_we), .wdata_o(wdata), .ptr_o(ptr), .idle_o(fsm_idle)
  );

  i2c_rp_regs #(.NPORT(NPORT)) u_regs (
    .clk_i, .rst_ni,
    .restore_i(~brst_s & devcfg0_o[0]),
    .we_i(reg_we), .waddr_i(ptr), .wdata_i(wdata), .raddr_i(ptr),
    .rdata_o(rdata), .ports_o(port_cfg_o), .cfg0_o(devcfg0_o), .cfg1_o(devcfg1_o)
  );
endmodule

module i2c_regptr_slave_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       brst_s,
  input logic       scl_s,
  input logic       idle,
  input logic       oe,
  input logic       tmo,
  input logic       we,
  input logic [7:0] ptr
);
  AST_IDLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |-> !oe); // R1
  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s) && brst_s && $past(brst_s) && !$past(tmo)) |-> $stable(oe)); // R2
  AST_WR_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |=> ptr == $past(ptr) + 8'd1); // R4
  AST_TMO_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo |=> (!oe && idle)); // R9
  AST_BRST_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !brst_s |=> (!oe && idle)); // R10
endmodule

bind i2c_regptr_slave i2c_regptr_slave_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .brst_s(brst_s), .scl_s(scl_s),
  .idle(fsm_idle), .oe(sda_oe_o), .tmo(tmo_fire), .we(reg_we), .ptr(ptr)
);

// File: tb/i2c_regptr_slave_tb.sv
module i2c_regptr_slave_tb;
  localparam int TMO = 4000;

  logic clk = 1'b0, rst_n = 1'b0, brst_n = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic [1:0] sel = 2'b00;
  logic sda_oe;
  logic [31:0] ports;
  logic [7:0] c0, c1;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  i2c_regptr_slave #(.TMO_CYC(TMO)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_rst_ni(brst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(sel), .sda_oe_o(sda_oe), .port_cfg_o(ports), .devcfg0_o(c0), .devcfg1_o(c1)
  );

  int total = 0, bad = 0;
  typedef struct { string tag; logic [7:0] val; } exp_t;
  exp_t exp_q[$];
  logic [7:0] obs_val;
  event obs_ev;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as bytes and acks come off the bus
  initial forever begin
    exp_t e;
    @(obs_ev);
    if (exp_q.size() == 0) begin
      total++; bad++;
      $display("FAIL unexpected item act=%h exp=none", obs_val);
    end else begin
      e = exp_q.pop_front();
      chk(e.tag, {24'b0, obs_val}, {24'b0, e.val});
    end
  end

  task automatic wq(); repeat (10) @(negedge clk); endtask
  task automatic start_c(); sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq(); endtask
  task automatic stop_c(); sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); endtask
  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(); scl = 1; wq(); s = sda_line; wq(); scl = 0; wq();
  endtask
  task automatic put_exp(string tag, logic [7:0] v);
    exp_t e; e.tag = tag; e.val = v; exp_q.push_back(e);
  endtask
  task automatic wr_byte(logic [7:0] b, logic ack, string tag);
    logic s;
    put_exp(tag, {7'b0, ack});
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    obs_val = {7'b0, ~s}; ->obs_ev;
  endtask
  task automatic rd_byte(logic [7:0] exp, logic last, string tag);
    logic s; logic [7:0] v;
    put_exp(tag, exp);
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); v[i] = s; end
    obs_val = v; ->obs_ev;
    clk_bit(last, s);
  endtask
  task automatic addr_hold(logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    sda_m = 1;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=done");
    finish_run();
  end

  initial begin
    logic s;
    repeat (5) @(negedge clk); rst_n = 1; wq();
    chk("R1 oe", {31'b0, sda_oe}, 0);
    chk("R1 ports", ports, 32'h80808080);
    chk("R1 cfg26", {24'b0, c0}, 32'hEC);
    chk("R1 cfg27", {24'b0, c1}, 32'h8F);

    sel = 2'b01;
    start_c(); wr_byte(8'h9A, 1, "R2 addr ack"); wr_byte(8'h02, 1, "R3 cmd ack");
    wr_byte(8'h11, 1, "R4 d0 ack"); wr_byte(8'h22, 1, "R4 d1 ack"); stop_c();
    chk("R4 burst write", ports, 32'h80221180);

    start_c(); wr_byte(8'h9A, 1, "R3 addr"); wr_byte(8'h01, 1, "R3 cmd"); stop_c();
    chk("R3 cmd only no write", ports, 32'h80221180);

    start_c(); wr_byte(8'h9B, 1, "R5 addr rd");
    rd_byte(8'h80, 0, "R5 rd 0x01"); rd_byte(8'h11, 0, "R5 rd 0x02"); rd_byte(8'h22, 1, "R5 rd 0x03");
    wq(); chk("R7 oe after nack", {31'b0, sda_oe}, 0);
    clk_bit(1'b1, s); chk("R7 no drive after nack", {31'b0, s}, 1);
    stop_c();

    start_c(); wr_byte(8'h9B, 1, "R5 addr rd2");
    rd_byte(8'h80, 0, "R5 persist 0x04"); rd_byte(8'h00, 1, "R6 rd 0x05"); stop_c();

    start_c(); wr_byte(8'h98, 0, "R2 mismatch nack"); wr_byte(8'h01, 0, "R2 ignored cmd");
    wr_byte(8'h55, 0, "R2 ignored data"); stop_c();
    chk("R2 mismatch no write", ports, 32'h80221180);

    start_c(); sel = 2'b10;
    wr_byte(8'h9A, 1, "R11 sel at start"); wr_byte(8'h04, 1, "R11 cmd");
    wr_byte(8'h44, 1, "R11 data"); wr_byte(8'h77, 1, "R6 write 0x05 acked"); stop_c();
    chk("R6 R11 regs", ports, 32'h44221180);

    start_c(); wr_byte(8'h9C, 1, "R11 new sel"); wr_byte(8'h05, 1, "R8 cmd");
    start_c(); wr_byte(8'h9D, 1, "R8 rs addr"); rd_byte(8'h00, 1, "R6 rd unimpl");
    start_c(); wr_byte(8'h9C, 1, "R8 rs2"); wr_byte(8'h03, 1, "R8 cmd2");
    start_c(); wr_byte(8'h9D, 1, "R8 rs3"); rd_byte(8'h22, 0, "R8 rd 0x03"); rd_byte(8'h44, 1, "R8 rd 0x04");
    stop_c();

    start_c(); wr_byte(8'h9C, 1, "R4 addr"); wr_byte(8'h26, 1, "R4 cmd cfg");
    wr_byte(8'hED, 1, "R4 cfg26"); wr_byte(8'h0F, 1, "R4 cfg27"); stop_c();
    chk("R4 cfg26 val", {24'b0, c0}, 32'hED);
    chk("R4 cfg27 val", {24'b0, c1}, 32'h0F);

    start_c(); addr_hold(8'h9C); repeat (8) @(negedge clk);
    chk("R9 ack held", {31'b0, sda_oe}, 1);
    repeat (TMO + 40) @(negedge clk);
    chk("R9 timeout release", {31'b0, sda_oe}, 0);
    start_c(); wr_byte(8'h9C, 1, "R9 recover"); wr_byte(8'h27, 1, "R9 cmd");
    wr_byte(8'h8F, 1, "R9 disarm"); stop_c();
    chk("R9 cfg27", {24'b0, c1}, 32'h8F);

    start_c(); addr_hold(8'h9C); repeat (TMO + 40) @(negedge clk);
    chk("R9 no timeout when disarmed", {31'b0, sda_oe}, 1);
    brst_n = 0; repeat (6) @(negedge clk);
    chk("R10 oe released", {31'b0, sda_oe}, 0);
    chk("R10 restore ports", ports, 32'h80808080);
    chk("R10 restore cfg26", {24'b0, c0}, 32'hEC);
    chk("R10 restore cfg27", {24'b0, c1}, 32'h8F);
    brst_n = 1; wq(); stop_c();

    start_c(); wr_byte(8'h9C, 1, "R10 addr"); wr_byte(8'h01, 1, "R10 cmd");
    wr_byte(8'h5A, 1, "R10 data"); stop_c();
    chk("R10 written", ports, 32'h8080805A);
    brst_n = 0; repeat (10) @(negedge clk); brst_n = 1; wq();
    chk("R10 keep regs", ports, 32'h8080805A);
    chk("R10 oe idle", {31'b0, sda_oe}, 0);
    start_c(); wr_byte(8'h9C, 1, "R10 after reset"); stop_c();

    wq();
    chk("queue drained", exp_q.size(), 0);
    finish_run();
  end
endmodule